// File: doc/BRIEF.md
# 2B+D PCM Serial Port

This block is the slave side of a serial PCM port that carries two 64 kbit/s B-channels in an 8 kHz frame. The external data clock runs at twice the bit rate, so each PCM bit lasts two data-clock periods. A frame begins when the frame sync is high at a data-clock rising edge. In each frame the port sends one parallel word MSB first on a serial line with a drive-enable, and collects one serial word into a parallel register. The word goes into one of two slots picked by a slot-select input. The second slot lies sixteen data-clock cycles after the first.

A fast system clock oversamples every external input through a synchronizer and derives edges from the samples. The port works only while a mode detector holds its flag. The detector watches a secondary clock input. When that input stays low across two or more frame-sync rising edges, the port is enabled. The flag drops as soon as that input changes level. When the port is not enabled, or when no frame sync arrives, the output line stays undriven.

Top module: `pcm2bd_port`

## Requirements
- R1: `mode_active` is 0 after reset. It becomes 1 once `aux_clk` has been low at MODE_SYNCS (default 2) consecutive `fsc` rising edges with no change of `aux_clk` between them.
- R2: Any change of level on `aux_clk` clears `mode_active` within a few system-clock cycles. A frame sync rise seen while `aux_clk` is high also clears it.
- R3: Data-clock rising edges are counted from the frame start, which is edge 1. With `slot_sel` = 0, bit 7-j of the captured transmit word appears on `dout` at edge 1+2j (j = 0..7) and holds for two data-clock periods.
- R4: With `slot_sel` = 1, the same transmit sequence is shifted by 16 edges. The MSB appears at edge 17 and the LSB at edge 31.
- R5: Receive samples `din` at the relative even edges 2, 4, ... 16, MSB first. These are absolute edges 2..16 for slot 0 and 18..32 for slot 1.
- R6: `rx_valid` is a one-system-cycle pulse, issued once per enabled frame, in the cycle after the eighth receive bit is taken. `rx_word` holds its value at all other times and is 0 after reset.
- R7: `dout_oe` rises at the relative edge 1. It falls at the data-clock falling edge that follows relative edge 16, so the drive window lasts 15.5 data-clock periods.
- R8: A frame that starts while `mode_active` is 0, or a stretch of data clock with no frame sync, leaves `dout_oe` low and produces no `rx_valid`.
- R9: `dout` is 0 whenever `dout_oe` is 0.
- R10: `slot_sel` and `tx_word` are captured at the frame start. Changing them later in the frame does not alter that frame's timing or data.
- R11: The frame starts at the first data-clock rising edge at which `fsc` is high. An `fsc` that rises earlier, while the data clock is low, does not move the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcl | input | 1 | Data clock, twice the PCM bit rate |
| fsc | input | 1 | Frame sync, 8 kHz |
| aux_clk | input | 1 | Secondary clock input watched by the mode detector |
| slot_sel | input | 1 | 0 = first B slot, 1 = second B slot |
| din | input | 1 | Serial receive data |
| tx_word | input | WORD_W | Parallel word to transmit |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Drive enable for `dout` (high = driven) |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |
| mode_active | output | 1 | Port enabled by the mode detector |

## Verification
An external edge reaches the outputs three system cycles after the input changes. That is two synchronizer stages plus the edge register, and the output register fires on the third edge. The bench holds each data-clock phase for eight system cycles. It checks `dout` and `dout_oe` on the seventh falling system-clock edge of each high and each low phase, well past that latency and before the next input change. `rx_valid` is due three cycles after the data-clock rise that carries the eighth receive bit. A monitor therefore compares `rx_word` on every falling system-clock edge where the strobe is high, against the word the driver queued for that frame. Mode changes are checked four system cycles after `aux_clk` moves, or after a whole frame.

// File: rtl/pcm2bd_pkg.sv
package pcm2bd_pkg;

   // Synchronized input bundle, one bit per external pin
   typedef struct packed {
      logic din;
      logic slot;
      logic aux;
      logic fsc;
      logic dcl;
   } pin_set_t;

   localparam int unsigned PIN_CNT = $bits(pin_set_t);

   // Position of an edge count inside the chosen slot: 1..span, 0 when outside
   function automatic int unsigned slot_pos(int unsigned cnt, logic slot, int unsigned span);
      int unsigned off;
      off = slot ? span : 0;
      if (cnt > off && cnt <= off + span)
         return cnt - off;
      return 0;
   endfunction

endpackage

// File: rtl/pcm2bd_in_sync.sv
module pcm2bd_in_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pcm2bd_in_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_stage[s-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= '0;
      else        q_prev <= q;
   end

endmodule

// File: rtl/pcm2bd_mode_det.sv
module pcm2bd_mode_det #(
   parameter int unsigned MODE_SYNCS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsc_rise,
   input  logic aux_lvl,
   input  logic aux_edge,
   output logic mode_active
);

   localparam int unsigned MCNT_W = $clog2(MODE_SYNCS + 1);

   logic [MCNT_W-1:0] low_syncs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_syncs   <= '0;
         mode_active <= 1'b0;
      end else if (aux_edge) begin
         low_syncs   <= '0;
         mode_active <= 1'b0;
      end else if (fsc_rise) begin
         if (aux_lvl) begin
            low_syncs   <= '0;
            mode_active <= 1'b0;
         end else begin
            if (32'(low_syncs) < MODE_SYNCS)
               low_syncs <= low_syncs + 1'b1;
            if (32'(low_syncs) + 1 >= MODE_SYNCS)
               mode_active <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/pcm2bd_frame_timer.sv
module pcm2bd_frame_timer #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned CNT_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dcl_rise,
   input  logic             fsc_lvl,
   input  logic             fsc_rise,
   input  logic             slot_lvl,
   input  logic             mode_active,
   output logic             tick,
   output logic             frame_start,
   output logic             frame_ok,
   output logic [CNT_W-1:0] pos_nxt,
   output logic [CNT_W-1:0] pos_cur
);

   import pcm2bd_pkg::*;

   localparam int unsigned SPAN    = 2 * WORD_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             sync_pending;
   logic [CNT_W-1:0] edge_cnt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             slot_q;
   logic             slot_eff;
   logic             ok_q;

   // Frame opens on the first data-clock rise that finds the sync high
   assign frame_start = dcl_rise & fsc_lvl & (sync_pending | fsc_rise);
   assign tick        = dcl_rise;

   always_comb begin
      if (frame_start)             cnt_nxt = CNT_W'(1);
      else if (edge_cnt == CNT_MAX) cnt_nxt = CNT_MAX;
      else                         cnt_nxt = edge_cnt + 1'b1;
   end

   assign slot_eff = frame_start ? slot_lvl    : slot_q;
   assign frame_ok = frame_start ? mode_active : ok_q;

   assign pos_nxt = CNT_W'(slot_pos(32'(cnt_nxt), slot_eff, SPAN));
   assign pos_cur = CNT_W'(slot_pos(32'(edge_cnt), slot_q, SPAN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_pending <= 1'b0;
         edge_cnt     <= CNT_MAX;
         slot_q       <= 1'b0;
         ok_q         <= 1'b0;
      end else begin
         if (frame_start)   sync_pending <= 1'b0;
         else if (fsc_rise) sync_pending <= 1'b1;
         if (dcl_rise) edge_cnt <= cnt_nxt;
         if (frame_start) begin
            slot_q <= slot_lvl;
            ok_q   <= mode_active;
         end
      end
   end

endmodule

// File: rtl/pcm2bd_slot_lane.sv
module pcm2bd_slot_lane #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              dcl_fall,
   input  logic              frame_start,
   input  logic              frame_ok,
   input  logic              mode_active,
   input  logic [CNT_W-1:0]  pos_nxt,
   input  logic [CNT_W-1:0]  pos_cur,
   input  logic              din_lvl,
   input  logic [WORD_W-1:0] tx_word,
   output logic              dout,
   output logic              dout_oe,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);

   localparam int unsigned SPAN  = 2 * WORD_W;
   localparam int unsigned IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

   logic [WORD_W-1:0] txw_q;
   logic [WORD_W-1:0] txw_eff;
   logic [WORD_W-1:0] rx_shift;
   logic              pos_odd;
   logic              pos_even;
   logic              tx_bit;
   logic [IDX_W-1:0]  bit_idx;

   assign txw_eff  = frame_start ? tx_word : txw_q;
   assign pos_odd  = (pos_nxt != '0) &  pos_nxt[0];
   assign pos_even = (pos_nxt != '0) & ~pos_nxt[0];

   always_comb begin
      if (pos_nxt == '0) bit_idx = IDX_W'(WORD_W - 1);
      else               bit_idx = IDX_W'(WORD_W - 1 - (32'(pos_nxt) - 1) / 2);
      tx_bit = txw_eff[bit_idx];
   end

   // Transmit side: drive on odd slot edges, release after the LSB's second fall
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txw_q   <= '0;
         dout    <= 1'b0;
         dout_oe <= 1'b0;
      end else begin
         if (frame_start) txw_q <= tx_word;
         if (!mode_active) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
         end else if (tick) begin
            if (frame_ok && pos_odd) begin
               dout    <= tx_bit;
               dout_oe <= 1'b1;
            end else if (frame_start) begin
               dout    <= 1'b0;
               dout_oe <= 1'b0;
            end
         end else if (dcl_fall && 32'(pos_cur) == SPAN) begin
            dout    <= 1'b0;
            dout_oe <= 1'b0;
         end
      end
   end

   // Receive side: sample on even slot edges, publish after the last bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_shift <= '0;
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (mode_active && tick && frame_ok && pos_even) begin
            rx_shift <= {rx_shift[WORD_W-2:0], din_lvl};
            if (32'(pos_nxt) == SPAN) begin
               rx_word  <= {rx_shift[WORD_W-2:0], din_lvl};
               rx_valid <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pcm2bd_port.sv
module pcm2bd_port #(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned CNT_W       = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MODE_SYNCS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dcl,
   input  logic              fsc,
   input  logic              aux_clk,
   input  logic              slot_sel,
   input  logic              din,
   input  logic [WORD_W-1:0] tx_word,
   output logic              dout,
   output logic              dout_oe,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              mode_active
);

   import pcm2bd_pkg::*;

   if (WORD_W < 2) begin : g_bad_word
      $error("pcm2bd_port: WORD_W must be at least 2");
   end
   if ((64'(1) << CNT_W) - 1 <= 64'(4 * WORD_W)) begin : g_bad_cnt
      $error("pcm2bd_port: CNT_W too small for two slots");
   end
   if (MODE_SYNCS < 1) begin : g_bad_mode
      $error("pcm2bd_port: MODE_SYNCS must be at least 1");
   end

   pin_set_t pins_raw, pins_s, pins_p;

   assign pins_raw = '{din: din, slot: slot_sel, aux: aux_clk, fsc: fsc, dcl: dcl};

   pcm2bd_in_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pins_raw),
      .q      (pins_s),
      .q_prev (pins_p)
   );

   logic dcl_rise, dcl_fall, fsc_rise, aux_edge;

   assign dcl_rise = pins_s.dcl & ~pins_p.dcl;
   assign dcl_fall = ~pins_s.dcl & pins_p.dcl;
   assign fsc_rise = pins_s.fsc & ~pins_p.fsc;
   assign aux_edge = pins_s.aux ^ pins_p.aux;

   pcm2bd_mode_det #(.MODE_SYNCS(MODE_SYNCS)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .fsc_rise    (fsc_rise),
      .aux_lvl     (pins_s.aux),
      .aux_edge    (aux_edge),
      .mode_active (mode_active)
   );

   logic             tick, frame_start, frame_ok;
   logic [CNT_W-1:0] pos_nxt, pos_cur;

   pcm2bd_frame_timer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .dcl_rise    (dcl_rise),
      .fsc_lvl     (pins_s.fsc),
      .fsc_rise    (fsc_rise),
      .slot_lvl    (pins_s.slot),
      .mode_active (mode_active),
      .tick        (tick),
      .frame_start (frame_start),
      .frame_ok    (frame_ok),
      .pos_nxt     (pos_nxt),
      .pos_cur     (pos_cur)
   );

   pcm2bd_slot_lane #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .dcl_fall    (dcl_fall),
      .frame_start (frame_start),
      .frame_ok    (frame_ok),
      .mode_active (mode_active),
      .pos_nxt     (pos_nxt),
      .pos_cur     (pos_cur),
      .din_lvl     (pins_s.din),
      .tx_word     (tx_word),
      .dout        (dout),
      .dout_oe     (dout_oe),
      .rx_word     (rx_word),
      .rx_valid    (rx_valid)
   );

endmodule

// File: rtl/pcm2bd_port_chk.sv
module pcm2bd_port_chk #(
   parameter int unsigned WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dcl_rise,
   input logic              dcl_fall,
   input logic              aux_edge,
   input logic              aux_lvl,
   input logic              mode_active,
   input logic              dout,
   input logic              dout_oe,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_valid
);

   assert_mode_rise_aux_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_active) |-> $past(!aux_lvl));

   assert_mode_clear_on_aux_R2: assert property (@(posedge clk) disable iff (!rst_n)
      aux_edge |=> !mode_active);

   assert_rx_on_dcl_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(dcl_rise));

   assert_rx_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_rx_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word));

   assert_oe_on_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_oe) |-> $past(dcl_rise));

   assert_oe_off_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_oe) |-> $past(dcl_fall || dcl_rise || !mode_active));

   assert_rx_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(mode_active));

   assert_dout_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> !dout);

endmodule

bind pcm2bd_port pcm2bd_port_chk #(.WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dcl_rise    (dcl_rise),
   .dcl_fall    (dcl_fall),
   .aux_edge    (aux_edge),
   .aux_lvl     (pins_s.aux),
   .mode_active (mode_active),
   .dout        (dout),
   .dout_oe     (dout_oe),
   .rx_word     (rx_word),
   .rx_valid    (rx_valid)
);

// File: tb/pcm2bd_port_bench.sv
module pcm2bd_port_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int EDGES      = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dcl = 1'b0, fsc = 1'b0, aux_clk = 1'b0, slot_sel = 1'b0, din = 1'b0;
   logic [7:0] tx_word = '0;
   logic       dout, dout_oe, rx_valid, mode_active;
   logic [7:0] rx_word;

   pcm2bd_port u_pcm2bd_port (
      .clk(clk), .rst_n(rst_n), .dcl(dcl), .fsc(fsc), .aux_clk(aux_clk),
      .slot_sel(slot_sel), .din(din), .tx_word(tx_word), .dout(dout),
      .dout_oe(dout_oe), .rx_word(rx_word), .rx_valid(rx_valid),
      .mode_active(mode_active)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] rx_q [$];

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clks(int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pop the expected receive word on every strobe
   always @(negedge clk) begin : rx_monitor
      logic [7:0] exp_w;
      if (rst_n && rx_valid) begin
         if (rx_q.size() == 0) check("R8 unexpected rx_valid", 1, 0);
         else begin
            exp_w = rx_q.pop_front();
            check("R5 rx_word", int'(rx_word), int'(exp_w));
         end
      end
   end

   // Driver: one frame of EDGES data-clock periods; pushes the expected rx word
   task automatic run_frame(bit sync, bit act, bit slot, logic [7:0] txw,
                            logic [7:0] rxw, bit flip, bit early);
      int    off;
      int    rel;
      int    nrel;
      bit    exp_oe;
      logic  exp_bit;
      string tag;
      off = slot ? 16 : 0;
      tag = flip ? "R10" : early ? "R11" : !act ? "R8" : slot ? "R4" : "R3";
      slot_sel = slot;
      tx_word  = txw;
      if (act) rx_q.push_back(rxw);
      dcl = 1'b0;
      fsc = sync && early;
      din = 1'b0;
      wait_clks(HALF);
      for (int k = 1; k <= EDGES; k++) begin
         dcl = 1'b1;
         fsc = sync && (k == 1);
         rel = k - off;
         exp_oe  = act && rel >= 1 && rel <= 16;
         exp_bit = exp_oe ? txw[7 - (rel - 1) / 2] : 1'b0;
         wait_clks(HALF - 1);
         check({tag, " oe high phase"}, int'(dout_oe), int'(exp_oe));
         check({tag, " dout high phase"}, int'(dout), int'(exp_bit));
         wait_clks(1);
         dcl = 1'b0;
         fsc = 1'b0;
         if (flip && k == 3) begin
            slot_sel = ~slot;
            tx_word  = ~txw;
         end
         nrel = k + 1 - off;
         if (nrel >= 2 && nrel <= 16 && nrel % 2 == 0) din = rxw[7 - (nrel / 2 - 1)];
         else                                          din = k[0];
         exp_oe  = act && rel >= 1 && rel <= 15;
         exp_bit = exp_oe ? txw[7 - (rel - 1) / 2] : 1'b0;
         wait_clks(HALF - 1);
         check("R7 oe low phase", int'(dout_oe), int'(exp_oe));
         check("R9 dout low phase", int'(dout), int'(exp_bit));
         wait_clks(1);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog act=running exp=finished");
         finish_run();
      end
   end

   initial begin
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(5);
      check("R1 mode after reset", int'(mode_active), 0);
      check("R8 oe after reset", int'(dout_oe), 0);
      check("R6 rx_valid after reset", int'(rx_valid), 0);
      check("R6 rx_word after reset", int'(rx_word), 0);

      // Two syncs with aux low enable the port; both frames stay idle
      run_frame(1, 0, 0, 8'h11, 8'h22, 0, 0);
      check("R1 mode after one sync", int'(mode_active), 0);
      run_frame(1, 0, 0, 8'h33, 8'h44, 0, 0);
      check("R1 mode after two syncs", int'(mode_active), 1);

      run_frame(1, 1, 0, 8'hA5, 8'h3C, 0, 0);
      run_frame(1, 1, 1, 8'h96, 8'hC3, 0, 0);
      run_frame(1, 1, 0, 8'hFF, 8'h00, 0, 1);
      run_frame(1, 1, 1, 8'h00, 8'hFF, 0, 0);
      run_frame(1, 1, 0, 8'h01, 8'h80, 1, 0);
      run_frame(1, 1, 1, 8'h6E, 8'h5B, 1, 1);

      // Data clock without any frame sync
      run_frame(0, 0, 0, 8'h77, 8'h99, 0, 0);
      check("R8 mode kept without sync", int'(mode_active), 1);

      // Toggling the secondary clock drops the mode at once
      aux_clk = 1'b1;
      wait_clks(4);
      check("R2 mode cleared on aux rise", int'(mode_active), 0);
      aux_clk = 1'b0;
      wait_clks(4);
      check("R2 mode still clear after aux fall", int'(mode_active), 0);

      run_frame(1, 0, 1, 8'h5A, 8'hA5, 0, 0);
      check("R2 mode after one new sync", int'(mode_active), 0);
      run_frame(1, 0, 0, 8'h5A, 8'hA5, 0, 0);
      check("R1 mode re-entered", int'(mode_active), 1);
      run_frame(1, 1, 0, 8'hC7, 8'hE1, 0, 0);

      wait_clks(4);
      check("R6 every queued word received", rx_q.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule